// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a 12-bit charge-balancing converter. Each conversion takes a fixed schedule of clock periods. The first periods track the analog input while the comparator autobalances. The remaining periods run a binary search, one result bit per clock. The search starts with the most significant bit and drives a trial code toward the capacitor array. After each trial it samples the single-bit comparator decision.

When the last bit is decided, the finished word moves into a held result register and a ready flag goes high. The register keeps that value through the whole of the following conversion.

An active-low start input selects the mode:
- Held low, the sequencer free-runs, producing one conversion per cycle.
- Held high when a cycle ends, the sequencer parks in track mode with the ready flag high. Pulling start low then resumes the cycle at the last track period.

The result leaves on two fields, an upper byte and a lower nibble. Each field has its own active-low enable and floats when that enable is off.

Top module: `sar_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in period 1 of track mode. After reset the trial code and the result register are zero, the ready flag is low, and track and autobalance are high.
- R2: With start held low, conversions follow each other without gaps. The ready flag rises once every 15 clock cycles.
- R3: In periods 1 to 3, the track and autobalance outputs are high and the trial code is zero. Both outputs are low in periods 4 to 15.
- R4: During period 4 the trial code is 0x800: bit 11 set, all other bits clear.
- R5: The comparator input is taken at the rising edge that ends each period from 4 to 15, testing bits 11 down to 0. A high comparator keeps the bit under test and a low one clears it. The result is straight binary (0 to 4095), so if the comparator is high exactly when the input code is at least the trial code, every input code converts to itself.
- R6: The result register changes only at the edge that enters period 1. It holds its value through all of the next conversion.
- R7: The ready flag rises at the same edge that loads the result. In free-running operation it falls at the edge that enters period 2.
- R8: Start is looked at only in period 1. If start is high there, the sequencer stays in period 1 with the ready flag high and the trial code zero. Raising start during a conversion does not stop that conversion.
- R9: When start goes low while parked, the next edge moves to period 3 and clears the ready flag. The next result is loaded 14 edges after that start edge.
- R10: When its enable is low, the upper output field drives result bits 11 to 4 and the lower field drives bits 3 to 0. A field whose enable is high is high impedance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low conversion start, sampled in period 1 |
| cmp_in | input | 1 | Comparator decision, high when input is at or above trial |
| oe_hi_n | input | 1 | Active-low enable of the upper output field |
| oe_lo_n | input | 1 | Active-low enable of the lower output field |
| track_en | output | 1 | Sample switch closed (array connected to input) |
| autobal | output | 1 | Comparator autobalance |
| trial | output | 12 | Trial code toward the capacitor array |
| dout_hi | output | 8 | Result bits 11 to 4, three-state |
| dout_lo | output | 4 | Result bits 3 to 0, three-state |
| drdy | output | 1 | Ready flag: a new result is held |

## Verification
The bench runs all 4096 codes through a comparator model and a table of edge codes (zero, full scale, alternating patterns). An off-by-one in the bit schedule or a reversed keep/clear decision would corrupt every result.

The park and resume path gets exact edge counts. A sequencer that restarted at period 1 or 2 after resume would load late, and one that ignored the park would drop the ready flag. Raising start during a conversion checks that the conversion is not aborted.

Result holding is checked mid-conversion, to catch a register that follows the trial code. Field enables are checked against a pulled-up bus, to catch a swapped or merged enable.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   // Period at whose closing edge result bit `bit_idx` is decided
   function automatic int test_period(input int track_n, input int width, input int bit_idx);
      return track_n + width - bit_idx;
   endfunction

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
   parameter int TRACK_N = 3,
   parameter int CYCLE   = 15,
   parameter int PW      = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start_n,
   output logic [PW-1:0] period,
   output logic          in_track,
   output logic          leave_first,
   output logic          load
);
   logic parked;

   assign in_track    = (period <= PW'(TRACK_N));
   assign leave_first = (period == PW'(1)) && !start_n;
   assign load        = (period == PW'(CYCLE));

   always_ff @(posedge clk) begin
      if (rst) begin
         period <= PW'(1);
         parked <= 1'b0;
      end else if (period == PW'(1)) begin
         if (start_n) begin
            parked <= 1'b1;
         end else begin
            period <= parked ? PW'(TRACK_N) : PW'(2);
            parked <= 1'b0;
         end
      end else if (load) begin
         period <= PW'(1);
      end else begin
         period <= period + PW'(1);
      end
   end
endmodule

// File: rtl/sar_seq_srch.sv
module sar_seq_srch
   import sar_seq_pkg::*;
#(
   parameter int W       = 12,
   parameter int TRACK_N = 3,
   parameter int CYCLE   = 15,
   parameter int PW      = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] period,
   input  logic          cmp_in,
   output logic [W-1:0]  trial,
   output logic [W-1:0]  word
);
   // Bit 0 is decided at the loading edge, so the word takes the live comparator
   assign word = {trial[W-1:1], cmp_in};

   for (genvar i = 0; i < W; i++) begin : g_bit
      localparam int TP = test_period(TRACK_N, W, i);
      always_ff @(posedge clk) begin
         if (rst)                        trial[i] <= 1'b0;
         else if (period == PW'(CYCLE))  trial[i] <= 1'b0;
         else if (period == PW'(TRACK_N)) trial[i] <= (i == W - 1) ? 1'b1 : 1'b0;
         else if (period == PW'(TP))     trial[i] <= cmp_in;
         else if (period == PW'(TP - 1)) trial[i] <= 1'b1;
      end
   end
endmodule

// File: rtl/sar_seq_obuf.sv
module sar_seq_obuf #(
   parameter int W    = 12,
   parameter int LO_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic            leave_first,
   input  logic [W-1:0]    word,
   input  logic            oe_hi_n,
   input  logic            oe_lo_n,
   output logic [W-1:0]    res,
   output logic            drdy,
   output logic [W-LO_W-1:0] dout_hi,
   output logic [LO_W-1:0] dout_lo
);
   always_ff @(posedge clk) begin
      if (rst) begin
         res  <= '0;
         drdy <= 1'b0;
      end else if (load) begin
         res  <= word;
         drdy <= 1'b1;
      end else if (leave_first) begin
         drdy <= 1'b0;
      end
   end

   assign dout_hi = oe_hi_n ? 'z : res[W-1:LO_W];
   assign dout_lo = oe_lo_n ? 'z : res[LO_W-1:0];
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
   parameter int W       = 12,
   parameter int TRACK_N = 3,
   parameter int LO_W    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_n,
   input  logic              cmp_in,
   input  logic              oe_hi_n,
   input  logic              oe_lo_n,
   output logic              track_en,
   output logic              autobal,
   output logic [W-1:0]      trial,
   output logic [W-LO_W-1:0] dout_hi,
   output logic [LO_W-1:0]   dout_lo,
   output logic              drdy
);
   localparam int CYCLE = TRACK_N + W;
   localparam int PW    = $clog2(CYCLE + 1);

   initial begin
      if (W < 2)                    $fatal(1, "W must be at least 2");
      if (TRACK_N < 2)              $fatal(1, "TRACK_N must be at least 2");
      if (LO_W < 1 || LO_W >= W)    $fatal(1, "LO_W must lie in 1..W-1");
   end

   logic [PW-1:0] period;
   logic          in_track, leave_first, load;
   logic [W-1:0]  word, res;

   sar_seq_timer #(.TRACK_N(TRACK_N), .CYCLE(CYCLE), .PW(PW)) u_timer (
      .clk(clk), .rst(rst), .start_n(start_n), .period(period),
      .in_track(in_track), .leave_first(leave_first), .load(load)
   );

   sar_seq_srch #(.W(W), .TRACK_N(TRACK_N), .CYCLE(CYCLE), .PW(PW)) u_srch (
      .clk(clk), .rst(rst), .period(period), .cmp_in(cmp_in),
      .trial(trial), .word(word)
   );

   sar_seq_obuf #(.W(W), .LO_W(LO_W)) u_obuf (
      .clk(clk), .rst(rst), .load(load), .leave_first(leave_first),
      .word(word), .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n),
      .res(res), .drdy(drdy), .dout_hi(dout_hi), .dout_lo(dout_lo)
   );

   assign track_en = in_track;
   assign autobal  = in_track;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int W = 12
) (
   input logic         clk,
   input logic         rst,
   input logic         track_en,
   input logic         drdy,
   input logic [W-1:0] trial,
   input logic [W-1:0] res
);
   AST_TRACK_TRIAL_ZERO: assert property (@(posedge clk) disable iff (rst)
      track_en |-> (trial == '0)); // R3

   AST_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
      $fell(track_en) |-> (trial == {1'b1, {(W-1){1'b0}}})); // R4

   AST_NO_READY_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
      !track_en |-> !drdy); // R7

   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
      !$rose(drdy) |-> $stable(res)); // R6

   AST_READY_DROP_IN_TRACK: assert property (@(posedge clk) disable iff (rst)
      $fell(drdy) |-> track_en); // R9
endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .track_en(track_en), .drdy(drdy),
   .trial(trial), .res(u_obuf.res)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
   localparam int CLK_P = 10;
   localparam int NV    = 8;
   localparam logic [23:0] VEC [NV] = '{
      {12'h000, 12'h000}, {12'hFFF, 12'hFFF}, {12'h800, 12'h800}, {12'h7FF, 12'h7FF},
      {12'hAAA, 12'hAAA}, {12'h555, 12'h555}, {12'h001, 12'h001}, {12'hFFE, 12'hFFE}
   };

   logic clk = 1'b0, rst = 1'b1, start_n = 1'b0, oe_hi_n = 1'b0, oe_lo_n = 1'b0;
   logic [11:0] ain = '0;
   logic        cmp_in, track_en, autobal, drdy;
   logic [11:0] trial;
   tri1  [7:0]  d_hi;
   tri1  [3:0]  d_lo;
   int errors = 0, checks = 0;

   always #(CLK_P/2) clk = ~clk;
   assign cmp_in = (ain >= trial);

   sar_seq u_sar_seq (
      .clk(clk), .rst(rst), .start_n(start_n), .cmp_in(cmp_in),
      .oe_hi_n(oe_hi_n), .oe_lo_n(oe_lo_n), .track_en(track_en), .autobal(autobal),
      .trial(trial), .dout_hi(d_hi), .dout_lo(d_lo), .drdy(drdy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int n;
      logic [11:0] held;
      tick(3);
      // R1 reset state
      chk("R1 drdy", drdy, 0);
      chk("R1 result", {d_hi, d_lo}, 0);
      chk("R1 trial", trial, 0);
      chk("R1 track", {track_en, autobal}, 2'b11);
      @(negedge clk) rst = 1'b0;
      @(posedge drdy); #1;

      // R5 table of codes
      for (int v = 0; v < NV; v++) begin
         ain = VEC[v][23:12];
         @(posedge drdy); #1;
         chk("R5 table", {d_hi, d_lo}, VEC[v][11:0]);
      end

      // R7 / R3 / R4 schedule of one cycle
      ain = 12'h3C5;
      tick(1);
      chk("R7 drdy low in period 2", drdy, 0);
      chk("R3 track in period 2", {track_en, autobal, trial}, {2'b11, 12'h000});
      tick(1);
      chk("R3 track in period 3", {track_en, trial}, {1'b1, 12'h000});
      tick(1);
      chk("R4 msb trial", {track_en, autobal, trial}, {2'b00, 12'h800});

      // R2 spacing and R6 hold
      @(posedge drdy); #1;
      chk("R5 mid code", {d_hi, d_lo}, 12'h3C5);
      held = {d_hi, d_lo};
      ain = 12'h0F0;
      tick(7);
      chk("R6 result held", {d_hi, d_lo}, held);
      n = 7;
      while (!drdy) begin tick(1); n++; end
      chk("R2 cycle length", n, 15);
      chk("R6 new result", {d_hi, d_lo}, 12'h0F0);

      // R8 start raised mid-conversion is ignored, then park
      ain = 12'h5A3;
      tick(4);
      start_n = 1'b1;
      n = 4;
      while (!drdy) begin tick(1); n++; end
      chk("R8 conversion completes", n, 15);
      chk("R8 result", {d_hi, d_lo}, 12'h5A3);
      ain = 12'h123;
      tick(20);
      chk("R8 parked drdy", drdy, 1);
      chk("R8 parked track", {track_en, trial}, {1'b1, 12'h000});
      chk("R8 parked result", {d_hi, d_lo}, 12'h5A3);

      // R10 enables on a pulled-up bus
      oe_hi_n = 1'b1; #1;
      chk("R10 hi off", {d_hi, d_lo}, {8'hFF, 4'h3});
      oe_hi_n = 1'b0; oe_lo_n = 1'b1; #1;
      chk("R10 lo off", {d_hi, d_lo}, {8'h5A, 4'hF});
      oe_lo_n = 1'b0; #1;

      // R9 resume at period 3
      @(negedge clk) start_n = 1'b0;
      tick(1);
      chk("R9 drdy drop", drdy, 0);
      chk("R9 still tracking", track_en, 1);
      tick(1);
      chk("R9 msb trial next", {track_en, trial}, {1'b0, 12'h800});
      tick(11);
      chk("R9 not yet loaded", drdy, 0);
      tick(1);
      chk("R9 loaded at 14th edge", drdy, 1);
      chk("R9 result", {d_hi, d_lo}, 12'h123);

      // R5 exhaustive sweep
      n = 0;
      for (int c = 0; c < 4096; c++) begin
         ain = 12'(c);
         @(posedge drdy); #1;
         checks++;
         if ({d_hi, d_lo} !== 12'(c)) begin
            errors++;
            $display("FAIL R5 sweep actual=%h expected=%h", {d_hi, d_lo}, 12'(c));
         end
      end

      // R1 reset in mid-run
      tick(6);
      @(negedge clk) rst = 1'b1;
      tick(1);
      chk("R1 mid reset", {drdy, track_en, trial, d_hi, d_lo}, {2'b01, 12'h000, 12'h000});
      @(negedge clk) rst = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule